// File: doc/BRIEF.md
# FIFO-fed pulse width modulator

This peripheral produces one pulse-width-modulated output under the control of a small 32-bit register bus. Software writes duty values into a four-word sample queue. The modulator takes a new duty value from the queue at each period boundary. It can hold each value for 1, 2, 4 or 8 periods before it moves on. If the queue has run dry at a boundary, the value already in use stays in force. The period is the programmed period value plus two ticks. A 12-bit prescaler sets the tick rate by dividing the block clock by 1 to 4096.

Each period starts with the output high. The output stays high until the counter reaches the active duty value and is low for the rest of the period. The output can also be inverted or held low. A status word reports queue occupancy, a write-overflow error, compare and roll-over events, and a low-occupancy mark against a programmable watermark. A self-clearing software reset returns every register to its idle value and flushes the queue.

Top module: `sampled_pwm`

## Requirements
- R1: After reset, every register reads zero except status, which reads 0x08. The output is low.
- R2: With prescaler field value p (divisor D = p+1) and period register P, one output period lasts D*(min(P,0xFFFE)+2) clock cycles. A P of 0xFFFF gives a period of 65536 cycles when D = 1.
- R3: In normal mode the output is high for D*min(S, min(P,0xFFFE)+2) cycles of each period, where S is the active duty value. S = 0 keeps the output low.
- R4: Control bits [19:18] select the output mode: 0 normal, 1 inverted, 2 and 3 held low.
- R5: While control bit 0 (enable) is clear, the output is low and the sample register (0x0C) reads 0.
- R6: Duty values leave the queue in write order, one per boundary. The first one loads on the first tick after enable. Status bits [2:0] hold the queue occupancy (0 to 4).
- R7: A sample write while the queue holds 4 words is dropped and sets status bit 6. Writing 1 to status bit 6 clears it.
- R8: Control bits [2:1] give how many periods each duty value is used: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8.
- R9: When the queue is empty at a reload boundary, the active duty value is kept.
- R10: Status bit 4 is set by a period roll-over and bit 5 by a compare match. Writing 1 to either bit clears it. Status bit 3 reads 1 while occupancy is at or below the watermark in control bits [27:26].
- R11: Writing control bit 3 resets all registers and flushes the queue. Control bit 3 reads 1 for SWR_CYCLES cycles and then clears itself.
- R12: Clock select bits [17:16] = 0 stops the counter. The output then keeps its current level.
- R13: Offsets are control 0x00, status 0x04, sample 0x0C and period 0x10. Read data appears on the cycle after the read. Other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read |
| pwm_out | output | 1 | Modulated output |

## Verification
A register read returns its value on the clock edge that follows the read strobe. The bench reads at the next falling edge. A write to enable starts the prescaler, and the first tick comes one edge after that write. That tick loads the first duty value, and the output register follows the counter by one more edge. Reads of the active duty value are therefore placed a counted number of edges after the enabling write, well inside a period, while duty and period are judged by counting high cycles over windows of whole periods, so the phase at which a window starts does not change the expected count.

// File: rtl/pwm_sample_pkg.sv
package pwm_sample_pkg;
  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_STAT = 5'h04;
  localparam logic [4:0] OFS_SAMP = 5'h0C;
  localparam logic [4:0] OFS_PER  = 5'h10;

  typedef enum logic [1:0] {
    OUT_NORMAL = 2'd0,
    OUT_INVERT = 2'd1,
    OUT_LOW    = 2'd2,
    OUT_LOW2   = 2'd3
  } out_mode_e;
endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_POP_ONLY_WHEN_FILLED: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst) (push && full && !pop) |=> full); // R7
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] div_m1,
  output logic         tick
);
  logic [W-1:0] pcnt;

  assign tick = run && (pcnt >= div_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst) !run |-> !tick); // R12
endmodule

// File: rtl/pwm_period_engine.sv
module pwm_period_engine
  import pwm_sample_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] period,
  input  logic [1:0]    rpt,
  input  logic [1:0]    omode,
  input  logic          fifo_empty,
  input  logic [CW-1:0] fifo_dout,
  output logic          pop,
  output logic [CW-1:0] act,
  output logic          roll_evt,
  output logic          cmp_evt,
  output logic          pwm_out
);
  localparam logic [CW-1:0] PER_CAP = {{(CW-1){1'b1}}, 1'b0};
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] cnt, per_eff, top;
  logic [2:0]    rep_left, reps_m1;
  logic          fresh, boundary, reload, level, next_out;

  always_comb begin
    per_eff  = (period > PER_CAP) ? PER_CAP : period;
    top      = per_eff + ONE;
    boundary = fresh || (cnt >= top);
    reload   = boundary && (fresh || rep_left == 3'd0);
    case (rpt)
      2'd0:    reps_m1 = 3'd0;
      2'd1:    reps_m1 = 3'd1;
      2'd2:    reps_m1 = 3'd3;
      default: reps_m1 = 3'd7;
    endcase
    level = (cnt < act);
    case (out_mode_e'(omode))
      OUT_NORMAL: next_out = level;
      OUT_INVERT: next_out = !level;
      default:    next_out = 1'b0;
    endcase
  end

  assign pop      = en && tick && reload && !fifo_empty;
  assign roll_evt = en && tick && boundary && !fresh;
  assign cmp_evt  = en && tick && !boundary && (act != '0) && ((cnt + ONE) == act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      act      <= '0;
      rep_left <= '0;
      fresh    <= 1'b1;
      pwm_out  <= 1'b0;
    end else begin
      pwm_out <= en ? next_out : 1'b0;
      if (!en) begin
        cnt      <= '0;
        rep_left <= '0;
        fresh    <= 1'b1;
      end else if (tick) begin
        if (boundary) begin
          cnt   <= '0;
          fresh <= 1'b0;
          if (reload) begin
            rep_left <= reps_m1;
            if (!fifo_empty) act <= fifo_dout;
          end else begin
            rep_left <= rep_left - 1'b1;
          end
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst) !en |=> !pwm_out); // R5
  AST_HELD_LOW_MODE: assert property (@(posedge clk) disable iff (rst) omode[1] |=> !pwm_out); // R4
  AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (rst) (en && !tick) |=> ($stable(cnt) && $stable(act))); // R12
endmodule

// File: rtl/sampled_pwm.sv
module sampled_pwm
  import pwm_sample_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int CNT_W      = 16,
  parameter int PRE_W      = 12,
  parameter int SWR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out
);
  localparam int OCC_W = $clog2(DEPTH+1);
  localparam int SR_W  = $clog2(SWR_CYCLES+1);

  logic             en_q;
  logic [1:0]       rpt_q, clk_q, mode_q, wm_q;
  logic [PRE_W-1:0] presc_q;
  logic [CNT_W-1:0] per_q;
  logic             werr_f, cmp_f, roll_f;
  logic [SR_W-1:0]  srst_cnt;
  logic             srst_busy, irst;
  logic             wr_ctrl, wr_stat, wr_samp, wr_per, rd_req, push;
  logic             tick, pop, fifo_full, fifo_empty, roll_evt, cmp_evt;
  logic [CNT_W-1:0] fifo_dout, act;
  logic [OCC_W-1:0] fifo_cnt;
  logic [31:0]      ctrl_rd, stat_rd;

  assign srst_busy = (srst_cnt != '0);
  assign irst      = rst || srst_busy;
  assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  assign wr_stat   = bus_sel && bus_wr && (bus_addr == OFS_STAT);
  assign wr_samp   = bus_sel && bus_wr && (bus_addr == OFS_SAMP);
  assign wr_per    = bus_sel && bus_wr && (bus_addr == OFS_PER);
  assign rd_req    = bus_sel && !bus_wr;
  assign push      = wr_samp && !srst_busy;

  always_ff @(posedge clk) begin
    if (rst)                                        srst_cnt <= '0;
    else if (wr_ctrl && bus_wdata[3] && !srst_busy) srst_cnt <= SR_W'(SWR_CYCLES);
    else if (srst_busy)                             srst_cnt <= srst_cnt - 1'b1;
  end

  // Field positions: enable [0], repeat [2:1], reset [3], prescale [15:4],
  // clock select [17:16], output mode [19:18], watermark [27:26].
  always_ff @(posedge clk) begin
    if (irst) begin
      en_q <= 1'b0; rpt_q <= '0; presc_q <= '0;
      clk_q <= '0; mode_q <= '0; wm_q <= '0;
      per_q <= '0;
    end else begin
      if (wr_ctrl && !bus_wdata[3]) begin
        en_q    <= bus_wdata[0];
        rpt_q   <= bus_wdata[2:1];
        presc_q <= bus_wdata[4 +: PRE_W];
        clk_q   <= bus_wdata[17:16];
        mode_q  <= bus_wdata[19:18];
        wm_q    <= bus_wdata[27:26];
      end
      if (wr_per) per_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (irst) begin
      werr_f <= 1'b0; cmp_f <= 1'b0; roll_f <= 1'b0;
    end else begin
      werr_f <= (werr_f && !(wr_stat && bus_wdata[6])) || (push && fifo_full);
      cmp_f  <= (cmp_f  && !(wr_stat && bus_wdata[5])) || cmp_evt;
      roll_f <= (roll_f && !(wr_stat && bus_wdata[4])) || roll_evt;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[0]          = en_q;
    ctrl_rd[2:1]        = rpt_q;
    ctrl_rd[3]          = srst_busy;
    ctrl_rd[4 +: PRE_W] = presc_q;
    ctrl_rd[17:16]      = clk_q;
    ctrl_rd[19:18]      = mode_q;
    ctrl_rd[27:26]      = wm_q;
    stat_rd = '0;
    stat_rd[OCC_W-1:0]  = fifo_cnt;
    stat_rd[3]          = (fifo_cnt <= OCC_W'(wm_q));
    stat_rd[4]          = roll_f;
    stat_rd[5]          = cmp_f;
    stat_rd[6]          = werr_f;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_req) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata <= ctrl_rd;
        OFS_STAT: bus_rdata <= stat_rd;
        OFS_SAMP: bus_rdata <= en_q ? 32'(act) : '0;
        OFS_PER:  bus_rdata <= 32'(per_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  pwm_sample_fifo #(.DEPTH(DEPTH), .W(CNT_W)) i_fifo (
    .clk(clk), .rst(irst), .push(push), .din(bus_wdata[CNT_W-1:0]), .pop(pop),
    .dout(fifo_dout), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  pwm_prescaler #(.W(PRE_W)) i_presc (
    .clk(clk), .rst(irst), .run(en_q && (clk_q != 2'd0)), .div_m1(presc_q), .tick(tick)
  );

  pwm_period_engine #(.CW(CNT_W)) i_engine (
    .clk(clk), .rst(irst), .en(en_q), .tick(tick), .period(per_q), .rpt(rpt_q),
    .omode(mode_q), .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .pop(pop),
    .act(act), .roll_evt(roll_evt), .cmp_evt(cmp_evt), .pwm_out(pwm_out)
  );

  AST_SRST_FLUSHES: assert property (@(posedge clk) disable iff (rst) srst_busy |=> (fifo_cnt == '0)); // R11
  AST_WERR_ON_FULL: assert property (@(posedge clk) disable iff (rst) (push && fifo_full) |=> werr_f); // R7
endmodule

// File: tb/test_sampled_pwm.sv
module test_sampled_pwm;
  localparam int SWR = 4;
  localparam logic [31:0] RUN = 32'h0001_0001;

  typedef struct packed {
    logic [1:0]  mode;
    logic [11:0] presc;
    logic [15:0] per;
    logic [15:0] samp;
    logic [15:0] win;
    logic [15:0] exp_hi;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'd0, 16'd6, 16'd3, 16'd32, 16'd12},
    '{2'd1, 12'd0, 16'd6, 16'd3, 16'd32, 16'd20},
    '{2'd0, 12'd0, 16'd6, 16'd0, 16'd32, 16'd0},
    '{2'd0, 12'd0, 16'd6, 16'd9, 16'd32, 16'd32},
    '{2'd2, 12'd0, 16'd6, 16'd3, 16'd32, 16'd0},
    '{2'd0, 12'd2, 16'd4, 16'd2, 16'd72, 16'd24},
    '{2'd1, 12'd0, 16'd6, 16'd0, 16'd32, 16'd32},
    '{2'd3, 12'd0, 16'd2, 16'd1, 16'd16, 16'd0},
    '{2'd0, 12'd1, 16'd0, 16'd1, 16'd16, 16'd8}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic pwm_out;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  sampled_pwm #(.SWR_CYCLES(SWR)) i_sampled_pwm (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    rv = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic swreset();
    wr(5'h00, 32'h8);
    idle(SWR + 2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int hi, per_len, hi_len;
    logic held;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R13: reset values and offsets
    check(pwm_out == 1'b0, "R1 output", pwm_out, 0);
    rd(5'h00); check(rv == 32'h0, "R1 ctrl", rv, 0);
    rd(5'h04); check(rv == 32'h8, "R1 status", rv, 8);
    rd(5'h10); check(rv == 32'h0, "R1 period", rv, 0);
    wr(5'h08, 32'h1234); rd(5'h08); check(rv == 32'h0, "R13 unmapped", rv, 0);

    // Vector table: R2, R3, R4
    for (int v = 0; v < NV; v++) begin
      swreset();
      wr(5'h10, 32'(VECS[v].per));
      wr(5'h0C, 32'(VECS[v].samp));
      wr(5'h00, RUN | (32'(VECS[v].mode) << 18) | (32'(VECS[v].presc) << 4));
      idle(40);
      measure(int'(VECS[v].win), hi);
      check(hi == int'(VECS[v].exp_hi), $sformatf("R2/R3/R4 vector %0d", v), hi, VECS[v].exp_hi);
    end

    // R6, R9: order and reuse
    swreset();
    wr(5'h10, 32'd6);
    wr(5'h0C, 32'd2); wr(5'h0C, 32'd5);
    rd(5'h04); check(rv[2:0] == 3'd2, "R6 occupancy", rv[2:0], 2);
    wr(5'h00, RUN);
    idle(2); rd(5'h0C); check(rv == 32'd2, "R6 first sample", rv, 2);
    idle(7); rd(5'h0C); check(rv == 32'd5, "R6 second sample", rv, 5);
    rd(5'h04); check(rv[2:0] == 3'd0, "R6 drained", rv[2:0], 0);
    idle(20); rd(5'h0C); check(rv == 32'd5, "R9 reuse on empty", rv, 5);

    // R8: repeat 2x
    swreset();
    wr(5'h10, 32'd6);
    wr(5'h0C, 32'd3); wr(5'h0C, 32'd1);
    wr(5'h00, RUN | 32'h2);
    idle(9); rd(5'h0C); check(rv == 32'd3, "R8 2x held", rv, 3);
    idle(7); rd(5'h0C); check(rv == 32'd1, "R8 2x advance", rv, 1);

    // R8: repeat 8x
    swreset();
    wr(5'h10, 32'd6);
    wr(5'h0C, 32'd7); wr(5'h0C, 32'd4);
    wr(5'h00, RUN | 32'h6);
    idle(58); rd(5'h0C); check(rv == 32'd7, "R8 8x held", rv, 7);
    idle(9); rd(5'h0C); check(rv == 32'd4, "R8 8x advance", rv, 4);

    // R7: overflow
    swreset();
    for (int k = 1; k <= 5; k++) wr(5'h0C, 32'(k));
    rd(5'h04); check(rv == 32'h44, "R7 full and error", rv, 32'h44);
    wr(5'h04, 32'h40);
    rd(5'h04); check(rv == 32'h04, "R7 error cleared", rv, 32'h04);

    // R10: watermark
    swreset();
    wr(5'h00, 32'h0800_0000);
    wr(5'h0C, 32'd1); wr(5'h0C, 32'd2);
    rd(5'h04); check(rv[3] == 1'b1, "R10 at watermark", rv[3], 1);
    wr(5'h0C, 32'd3);
    rd(5'h04); check(rv[3] == 1'b0, "R10 above watermark", rv[3], 0);

    // R10: events
    swreset();
    wr(5'h10, 32'd6); wr(5'h0C, 32'd3);
    wr(5'h00, RUN); idle(30);
    wr(5'h00, 32'h0);
    rd(5'h04); check(rv[5:4] == 2'b11, "R10 events set", rv[5:4], 3);
    wr(5'h04, 32'h30);
    rd(5'h04); check(rv[5:4] == 2'b00, "R10 events cleared", rv[5:4], 0);

    // R11: software reset
    wr(5'h10, 32'd9);
    wr(5'h00, 32'h8);
    rd(5'h00); check(rv == 32'h8, "R11 busy", rv, 8);
    idle(6);
    rd(5'h00); check(rv == 32'h0, "R11 self clear", rv, 0);
    rd(5'h10); check(rv == 32'h0, "R11 period reset", rv, 0);

    // R5: disabled
    swreset();
    wr(5'h10, 32'd6); wr(5'h0C, 32'd3);
    wr(5'h00, RUN); idle(20);
    wr(5'h00, 32'h0001_0000); idle(2);
    measure(32, hi); check(hi == 0, "R5 low when disabled", hi, 0);
    rd(5'h0C); check(rv == 32'h0, "R5 sample reads zero", rv, 0);

    // R12: clock off freezes
    swreset();
    wr(5'h10, 32'd6); wr(5'h0C, 32'd3);
    wr(5'h00, RUN); idle(21);
    wr(5'h00, 32'h1); idle(2);
    held = pwm_out;
    measure(32, hi); check(hi == (held ? 32 : 0), "R12 output held", hi, held ? 32 : 0);

    // R2: period cap
    swreset();
    wr(5'h10, 32'hFFFF); wr(5'h0C, 32'd10);
    wr(5'h00, RUN);
    begin
      logic prev;
      prev = pwm_out;
      while (!(pwm_out && !prev)) begin prev = pwm_out; @(negedge clk); end
      per_len = 0; hi_len = 0; prev = pwm_out;
      do begin
        if (pwm_out) hi_len++;
        per_len++;
        prev = pwm_out;
        @(negedge clk);
      end while (!(pwm_out && !prev));
    end
    check(per_len == 65536, "R2 capped period", per_len, 65536);
    check(hi_len == 10, "R3 high time long period", hi_len, 10);

    finish_run();
  end
endmodule